// File: doc/BRIEF.md
# Line-Synchronized Thyristor Firing Generator

This block produces the gate pulses for a phase-controlled thyristor rectifier. An upstream detector delivers a one-clock strobe at each positive-going zero crossing of the mains. The block divides the mains period into control intervals and gives one firing pulse per interval. The number of intervals per period, and so the number of thyristors fired in turn, comes from a mode input: one for a single-phase half-wave stage, two for a single-phase full-wave stage, three for a three-pulse stage and six for a six-pulse bridge. Each pulse is delayed from its interval start by the firing delay `alpha`, given in clocks, and lasts a programmable number of clocks.

At the start of every interval the block raises a one-clock sample strobe, so an external current regulator can update `alpha` once per control interval. The delay is captured only at interval starts and the mode only at cycle starts, so a pulse already in flight is never disturbed. If the zero-cross strobes stop arriving, the block drops out of synchronization and keeps every gate low until the next strobe. The nominal mains period and the loss-of-sync timeout are parameters in clocks.

Top module: `scr_fire_gen`

## Requirements
- R1: After reset, and until the first zero-cross strobe, `gate` is all zero and `sampleStb` stays low whatever the other inputs do.
- R2: Mode 2'b00 (half-wave) uses one interval of LINE_CLKS clocks per cycle and fires only gate bit 0.
- R3: Mode 2'b01 (full-wave) uses two intervals of LINE_CLKS/2 clocks and fires gate bits 0 then 1.
- R4: Mode 2'b10 (three-pulse) uses three intervals of LINE_CLKS/3 clocks and fires gate bits 0, 1, 2 in turn.
- R5: Mode 2'b11 (six-pulse) uses six intervals of LINE_CLKS/6 clocks and fires gate bits 0 to 5 in turn.
- R6: The gate bit of an interval rises exactly alpha+1 clocks after the clock in which that interval's `sampleStb` is high.
- R7: A pulse lasts `pulseWidth` clocks, taking the width present at the firing clock; a width of 0 gives no pulse. At most one gate bit is high at a time, and a new firing replaces a pulse still running.
- R8: If the captured alpha is greater than or equal to the interval length, that interval gives no pulse.
- R9: `alpha` is captured on the clock edge that starts an interval; a change during the interval only takes effect from the next interval.
- R10: `mode` is captured only on the edge that starts a cycle (a zero-cross strobe, or the wrap after the last interval); a change mid-cycle does not alter the rest of that cycle.
- R11: `sampleStb` is high for exactly one clock at the start of every interval while synchronized, and low otherwise.
- R12: A zero-cross strobe sampled at a clock edge restarts interval 0 of a new cycle from the next clock, wherever the sequence stood; without strobes the interval sequence wraps freely back to interval 0 after the last interval.
- R13: If TIMEOUT_CLKS clock edges pass after the last zero-cross strobe with no new one, the gates and `sampleStb` go low (cutting any running pulse) from the next clock until a new strobe arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| zeroCross | input | 1 | One-clock strobe at each mains zero crossing |
| alpha | input | ALPHA_W | Firing delay in clocks from the interval start |
| mode | input | 2 | Rectifier mode: 00 half-wave, 01 full-wave, 10 three-pulse, 11 six-pulse |
| pulseWidth | input | PW_W | Gate pulse length in clocks |
| gate | output | 6 | Gate pulse lines, bit index is the thyristor order |
| sampleStb | output | 1 | One-clock strobe at each control interval start |

## Verification
The main function is swept over every mode against delays of zero, one, mid-interval, the last legal count, exactly the interval length and beyond it, each with pulse widths of zero, one and several clocks. Zero delay and last-count delay separate an off-by-one in the delay compare from a correct one. The delay equal to the length tells a strict compare from an inclusive one, and the long pulse at the last count shows spill into the next interval. Each sweep keeps strobes coming for two periods and then stops them, so the free-running wrap and the timeout cut-off are seen in the same run. Directed patterns change alpha or mode mid-interval and send an early zero-cross, which separates correct capture points and resync from designs that sample continuously or ignore the strobe.

// File: rtl/scr_fire_pkg.sv
package scr_fire_pkg;

  typedef enum logic [1:0] {
    MODE_HALF = 2'b00,
    MODE_FULL = 2'b01,
    MODE_TRI  = 2'b10,
    MODE_SIX  = 2'b11
  } fireMode_e;

  localparam int unsigned NUM_GATES = 6;
  localparam int unsigned IDX_W     = $clog2(NUM_GATES);

  // Strobes and state handed from the control to the datapath each clock.
  typedef struct packed {
    logic             startCycle;
    logic             startInterval;
    logic             loseSync;
    logic             synced;
    logic [IDX_W-1:0] phaseIdx;
  } fireStrb_t;

endpackage

// File: rtl/scr_fire_ctrl.sv
module scr_fire_ctrl
  import scr_fire_pkg::*;
#(
  parameter int unsigned LINE_CLKS    = 1000000,
  parameter int unsigned TIMEOUT_CLKS = 1500000,
  parameter int unsigned POS_W        = 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             zeroCross,
  input  fireMode_e        modeQ,
  output fireStrb_t        strb,
  output logic [POS_W-1:0] posCnt,
  output logic [POS_W-1:0] intLen
);

  localparam int unsigned AGE_W = $clog2(TIMEOUT_CLKS + 1);
  localparam logic [POS_W-1:0] LEN_HALF = POS_W'(LINE_CLKS);
  localparam logic [POS_W-1:0] LEN_FULL = POS_W'(LINE_CLKS / 2);
  localparam logic [POS_W-1:0] LEN_TRI  = POS_W'(LINE_CLKS / 3);
  localparam logic [POS_W-1:0] LEN_SIX  = POS_W'(LINE_CLKS / 6);
  localparam logic [AGE_W-1:0] AGE_LAST = AGE_W'(TIMEOUT_CLKS - 1);

  logic             inSync;
  logic [AGE_W-1:0] age;
  logic [IDX_W-1:0] phaseIdx;
  logic [IDX_W-1:0] lastPhase;
  logic             atEnd;
  logic             timeoutNow;

  always_comb begin
    case (modeQ)
      MODE_HALF: begin intLen = LEN_HALF; lastPhase = IDX_W'(0); end
      MODE_FULL: begin intLen = LEN_FULL; lastPhase = IDX_W'(1); end
      MODE_TRI:  begin intLen = LEN_TRI;  lastPhase = IDX_W'(2); end
      default:   begin intLen = LEN_SIX;  lastPhase = IDX_W'(5); end
    endcase
  end

  assign atEnd      = inSync && (posCnt == intLen - POS_W'(1));
  assign timeoutNow = inSync && !zeroCross && (age == AGE_LAST);

  always_comb begin
    strb.startInterval = zeroCross || (atEnd && !timeoutNow);
    strb.startCycle    = zeroCross || (atEnd && !timeoutNow && phaseIdx == lastPhase);
    strb.loseSync      = timeoutNow;
    strb.synced        = inSync;
    strb.phaseIdx      = phaseIdx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inSync   <= 1'b0;
      age      <= '0;
      posCnt   <= '0;
      phaseIdx <= '0;
    end else if (zeroCross) begin
      inSync   <= 1'b1;
      age      <= '0;
      posCnt   <= '0;
      phaseIdx <= '0;
    end else if (timeoutNow) begin
      inSync   <= 1'b0;
      age      <= '0;
      posCnt   <= '0;
      phaseIdx <= '0;
    end else if (inSync) begin
      age <= age + AGE_W'(1);
      if (atEnd) begin
        posCnt   <= '0;
        phaseIdx <= (phaseIdx == lastPhase) ? '0 : phaseIdx + IDX_W'(1);
      end else begin
        posCnt <= posCnt + POS_W'(1);
      end
    end
  end

endmodule

// File: rtl/scr_fire_dp.sv
module scr_fire_dp
  import scr_fire_pkg::*;
#(
  parameter int unsigned ALPHA_W = 20,
  parameter int unsigned PW_W    = 12,
  parameter int unsigned POS_W   = 20
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  fireStrb_t            strb,
  input  logic [POS_W-1:0]     posCnt,
  input  logic [POS_W-1:0]     intLen,
  input  logic [ALPHA_W-1:0]   alpha,
  input  logic [1:0]           mode,
  input  logic [PW_W-1:0]      pulseWidth,
  output fireMode_e            modeQ,
  output logic [NUM_GATES-1:0] gate,
  output logic                 sampleStb
);

  localparam int unsigned CMP_W = (ALPHA_W > POS_W) ? ALPHA_W : POS_W;

  logic [ALPHA_W-1:0]   alphaQ;
  logic [PW_W-1:0]      left;
  logic [NUM_GATES-1:0] gateQ;
  logic [NUM_GATES-1:0] hot;
  logic                 fire;

  for (genvar g = 0; g < NUM_GATES; g++) begin : g_hot
    assign hot[g] = (strb.phaseIdx == IDX_W'(g));
  end

  assign fire = strb.synced && !strb.loseSync
             && (CMP_W'(posCnt) == CMP_W'(alphaQ))
             && (CMP_W'(alphaQ) < CMP_W'(intLen))
             && (pulseWidth != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      alphaQ    <= '0;
      modeQ     <= MODE_HALF;
      left      <= '0;
      gateQ     <= '0;
      sampleStb <= 1'b0;
    end else begin
      sampleStb <= strb.startInterval;
      if (strb.startInterval) alphaQ <= alpha;
      if (strb.startCycle)    modeQ  <= fireMode_e'(mode);
      if (strb.loseSync) begin
        gateQ <= '0;
        left  <= '0;
      end else if (fire) begin
        gateQ <= hot;
        left  <= pulseWidth - PW_W'(1);
      end else if (gateQ != '0) begin
        if (left == '0) gateQ <= '0;
        else            left  <= left - PW_W'(1);
      end
    end
  end

  assign gate = gateQ;

endmodule

// File: rtl/scr_fire_gen.sv
module scr_fire_gen
  import scr_fire_pkg::*;
#(
  parameter int unsigned LINE_CLKS    = 1000000,
  parameter int unsigned TIMEOUT_CLKS = 1500000,
  parameter int unsigned ALPHA_W      = 20,
  parameter int unsigned PW_W         = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               zeroCross,
  input  logic [ALPHA_W-1:0] alpha,
  input  logic [1:0]         mode,
  input  logic [PW_W-1:0]    pulseWidth,
  output logic [5:0]         gate,
  output logic               sampleStb
);

  localparam int unsigned POS_W = $clog2(LINE_CLKS + 1);

  fireStrb_t        strb;
  fireMode_e        modeQ;
  logic [POS_W-1:0] posCnt;
  logic [POS_W-1:0] intLen;

  scr_fire_ctrl #(
    .LINE_CLKS   (LINE_CLKS),
    .TIMEOUT_CLKS(TIMEOUT_CLKS),
    .POS_W       (POS_W)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .zeroCross(zeroCross),
    .modeQ    (modeQ),
    .strb     (strb),
    .posCnt   (posCnt),
    .intLen   (intLen)
  );

  scr_fire_dp #(
    .ALPHA_W(ALPHA_W),
    .PW_W   (PW_W),
    .POS_W  (POS_W)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .posCnt    (posCnt),
    .intLen    (intLen),
    .alpha     (alpha),
    .mode      (mode),
    .pulseWidth(pulseWidth),
    .modeQ     (modeQ),
    .gate      (gate),
    .sampleStb (sampleStb)
  );

endmodule

// File: rtl/scr_fire_chk.sv
module scr_fire_chk #(
  parameter int unsigned LINE_CLKS    = 1000000,
  parameter int unsigned TIMEOUT_CLKS = 1500000,
  parameter int unsigned PW_W         = 12
) (
  input logic            clk,
  input logic            rstN,
  input logic            zeroCross,
  input logic [PW_W-1:0] pulseWidth,
  input logic [5:0]      gate,
  input logic            sampleStb
);

  localparam int unsigned AGE_W = $clog2(TIMEOUT_CLKS + 1);
  localparam logic        LONG  = (LINE_CLKS >= 12);

  // Clock edges since the last zero-cross strobe, saturating at the timeout.
  logic [AGE_W-1:0] zcAge;

  always_ff @(posedge clk) begin
    if (!rstN)                               zcAge <= AGE_W'(TIMEOUT_CLKS);
    else if (zeroCross)                      zcAge <= '0;
    else if (zcAge < AGE_W'(TIMEOUT_CLKS))   zcAge <= zcAge + AGE_W'(1);
  end

  assert_one_gate_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(gate));

  assert_strobe_single_R11: assert property (@(posedge clk) disable iff (!rstN)
    (LONG && sampleStb && !zeroCross) |=> !sampleStb);

  assert_quiet_unsynced_R13: assert property (@(posedge clk) disable iff (!rstN)
    (zcAge >= AGE_W'(TIMEOUT_CLKS)) |-> (gate == 6'b0 && !sampleStb));

  assert_zc_restart_R12: assert property (@(posedge clk) disable iff (!rstN)
    zeroCross |=> sampleStb);

  assert_zero_width_R7: assert property (@(posedge clk) disable iff (!rstN)
    (pulseWidth == '0 && gate == 6'b0) |=> (gate == 6'b0));

endmodule

bind scr_fire_gen scr_fire_chk #(
  .LINE_CLKS   (LINE_CLKS),
  .TIMEOUT_CLKS(TIMEOUT_CLKS),
  .PW_W        (PW_W)
) i_scr_fire_chk (
  .clk       (clk),
  .rstN      (rstN),
  .zeroCross (zeroCross),
  .pulseWidth(pulseWidth),
  .gate      (gate),
  .sampleStb (sampleStb)
);

// File: tb/test_scr_fire_gen.sv
`timescale 1ns/1ps
module test_scr_fire_gen;

  localparam int LINE    = 60;
  localparam int TMO     = 90;
  localparam int AW      = 8;
  localparam int PWW     = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          zeroCross = 1'b0;
  logic [AW-1:0] alpha = '0;
  logic [1:0]    mode = 2'b00;
  logic [PWW-1:0] pulseWidth = '0;
  logic [5:0]    gate;
  logic          sampleStb;

  int total = 0;
  int fails = 0;
  int cyc   = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  scr_fire_gen #(
    .LINE_CLKS   (LINE),
    .TIMEOUT_CLKS(TMO),
    .ALPHA_W     (AW),
    .PW_W        (PWW)
  ) i_scr_fire_gen (
    .clk       (clk),
    .rstN      (rstN),
    .zeroCross (zeroCross),
    .alpha     (alpha),
    .mode      (mode),
    .pulseWidth(pulseWidth),
    .gate      (gate),
    .sampleStb (sampleStb)
  );

  task automatic chk(input string req, input logic [5:0] expG, input logic expS);
    total++;
    if (gate !== expG || sampleStb !== expS) begin
      fails++;
      $display("FAIL %s cyc=%0d gate=%b strobe=%b expected gate=%b strobe=%b",
               req, cyc, gate, sampleStb, expG, expS);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    cyc++;
  endtask

  task automatic stepTo(input int t);
    while (cyc < t) step();
  endtask

  // Drive a zero-cross strobe; cycle 0 is the first interval's strobe cycle.
  task automatic startZc();
    zeroCross = 1'b1;
    step();
    zeroCross = 1'b0;
    cyc = 0;
  endtask

  function automatic int phases(input logic [1:0] m);
    case (m)
      2'b00: return 1;
      2'b01: return 2;
      2'b10: return 3;
      default: return 6;
    endcase
  endfunction

  function automatic logic [5:0] expGate(input int n, input int len, input int k,
                                         input int a, input int p, input int syncEnd);
    if (n >= syncEnd || a >= len || p == 0) return 6'b0;
    for (int j = n / len; j >= 0 && j >= n / len - 2; j--) begin
      int nf = j * len + a;
      if (n >= nf + 1 && n <= nf + p) return 6'(1) << (j % k);
    end
    return 6'b0;
  endfunction

  task automatic sweep(input logic [1:0] m, input int a, input int p);
    int k = phases(m);
    int len = LINE / k;
    int syncEnd = LINE + TMO;
    string tag;
    case (m)
      2'b00: tag = "R2 R6 R7 R8 R11 R12 R13";
      2'b01: tag = "R3 R6 R7 R8 R11 R12 R13";
      2'b10: tag = "R4 R6 R7 R8 R11 R12 R13";
      default: tag = "R5 R6 R7 R8 R11 R12 R13";
    endcase
    mode = m;
    alpha = AW'(a);
    pulseWidth = PWW'(p);
    startZc();
    for (int n = 0; n <= 2 * LINE + 40; n++) begin
      if (n > 0) step();
      chk(tag, expGate(n, len, k, a, p, syncEnd), (n < syncEnd) && (n % len == 0));
      zeroCross = (n == LINE - 1);
    end
    zeroCross = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      total++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin : main
    repeat (5) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    cyc = 0;

    // R1: no output before the first zero crossing
    mode = 2'b11; alpha = AW'(0); pulseWidth = PWW'(3);
    for (int n = 0; n < 70; n++) begin
      step();
      chk("R1", 6'b0, 1'b0);
    end

    // R9: alpha changed mid-interval takes effect next interval
    mode = 2'b01; alpha = AW'(5); pulseWidth = PWW'(2);
    startZc();
    stepTo(2); alpha = AW'(20);
    stepTo(6);  chk("R9", 6'b000001, 1'b0);
    stepTo(21); chk("R9", 6'b000000, 1'b0);
    stepTo(30); chk("R9", 6'b000000, 1'b1);
    stepTo(36); chk("R9", 6'b000000, 1'b0);
    stepTo(51); chk("R9", 6'b000010, 1'b0);
    stepTo(52); chk("R9", 6'b000010, 1'b0);
    stepTo(53); chk("R9", 6'b000000, 1'b0);
    stepTo(200);

    // R10: mode changed mid-cycle takes effect at the next cycle start
    mode = 2'b11; alpha = AW'(0); pulseWidth = PWW'(1);
    startZc();
    stepTo(3);  mode = 2'b01;
    stepTo(11); chk("R10", 6'b000010, 1'b0);
    stepTo(41); chk("R10", 6'b010000, 1'b0);
    stepTo(59); zeroCross = 1'b1;
    step();     zeroCross = 1'b0;
    chk("R10", 6'b000000, 1'b1);
    stepTo(61); chk("R10", 6'b000001, 1'b0);
    stepTo(70); chk("R10", 6'b000000, 1'b0);
    stepTo(90); chk("R10", 6'b000000, 1'b1);
    stepTo(91); chk("R10", 6'b000010, 1'b0);
    stepTo(300);

    // R12: early zero crossing restarts interval 0
    mode = 2'b10; alpha = AW'(6); pulseWidth = PWW'(1);
    startZc();
    stepTo(7);  chk("R12", 6'b000001, 1'b0);
    stepTo(24); zeroCross = 1'b1;
    step();     zeroCross = 1'b0;
    chk("R12", 6'b000000, 1'b1);
    stepTo(27); chk("R12", 6'b000000, 1'b0);
    stepTo(32); chk("R12", 6'b000001, 1'b0);
    stepTo(40); chk("R12", 6'b000000, 1'b0);
    stepTo(45); chk("R12", 6'b000000, 1'b1);
    stepTo(52); chk("R12", 6'b000010, 1'b0);
    stepTo(200);

    // Sweeps over every mode, delay corner and width
    for (int m = 0; m < 4; m++) begin
      int len = LINE / phases(2'(m));
      int aList[6] = '{0, 1, len / 2, len - 1, len, len + 5};
      int pList[3] = '{0, 1, 5};
      for (int ai = 0; ai < 6; ai++) begin
        for (int pi = 0; pi < 3; pi++) begin
          sweep(2'(m), aList[ai], pList[pi]);
        end
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule